// File: doc/BRIEF.md
# Receive Ring Buffer Writer

This block places incoming Ethernet frames into a circular packet store that is divided into 256-byte pages. A frame arrives as a byte stream that is marked with start, valid and last flags. When the frame's first byte arrives, the block decides whether the frame can be kept. The stop command, a badly set up ring or too little free space each cause the whole frame to be thrown away. An accepted frame's body goes into the store through a byte-wide write port, starting four bytes into the current page. Page by page, the body wraps from the stop page back to the start page.

Frames shorter than the Ethernet minimum are filled out with zero bytes. After the last body byte, the block writes a four-byte header at the top of the first page. The header holds a status byte, the page where the next frame will begin, and the stored length. In the cycle of the final header byte, the block publishes the new current page and raises a receive-done strobe. Software reading the ring therefore never finds a header that points at a body still being written. The ring bounds, the boundary (reader) page and the current (writer) page come from the surrounding register file. The block only proposes the updated current page.

Top module: `rx_ring_writer`

## Requirements
- R1: A frame whose first byte arrives while the ring stop page is less than or equal to the ring start page causes no store writes and no current-page update.
- R2: Free pages are taken at the first byte. If current < boundary, they are boundary − current. Otherwise they are (stop − start) − (current − boundary). The frame is kept only when free pages × 256 ≥ 1518, which means at least 6 pages. Otherwise the frame causes no writes and no update.
- R3: A frame whose first byte arrives while `stopCmd` is high is dropped with no writes and no update.
- R4: The body bytes of a kept frame are written in arrival order. The first byte goes to address current×256 + 4, and each following byte goes to the next address. No byte is written past the stored length.
- R5: When a body write leaves the last byte of page stop−1, the next byte goes to byte 0 of the start page. Every write falls inside pages [start, stop).
- R6: A frame shorter than 60 bytes is followed by zero bytes until exactly 60 body bytes have been stored. A frame of 60 bytes or more gets no padding.
- R7: The header sits at current×256 + 0..3. In that order it holds status 0x01, the next page, the low byte of the length and the high byte of the length. The length is the stored body length plus 4.
- R8: The next page is current + ⌈(length + 4) / 256⌉. If that reaches or passes the stop page, (stop − start) is subtracted from it.
- R9: A kept frame produces exactly one `curPgWr` pulse carrying the next page on `curPgNext`, and exactly one `rxOkSet` pulse in the same cycle.
- R10: The header is written after the whole body, at offsets 0, 1, 2, 3 on consecutive cycles. The commit pulse comes in the cycle of offset 3.
- R11: If a new start flag arrives before the running frame's last byte, both frames are dropped and the current page is not updated.
- R12: A frame that starts while padding or the header of an earlier frame is in progress is dropped without any writes.
- R13: After reset, no write or commit is issued until a frame is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stopCmd | input | 1 | Receiver halted; new frames are dropped |
| ringStart | input | 8 | First page of the ring |
| ringStop | input | 8 | Page one past the end of the ring |
| boundaryPg | input | 8 | Reader position page |
| curPg | input | 8 | Writer position page |
| inStart | input | 1 | First byte of a frame |
| inValid | input | 1 | Byte on `inData` is valid |
| inLast | input | 1 | Final byte of a frame |
| inData | input | 8 | Frame byte |
| memWe | output | 1 | Store write enable |
| memAddr | output | 16 | Store byte address (page × 256 + offset) |
| memData | output | 8 | Store write data |
| curPgWr | output | 1 | Current page update strobe |
| curPgNext | output | 8 | New current page |
| rxOkSet | output | 1 | Receive-done status strobe |

## Verification
A wrong write pointer shows up within one byte as a body byte at the wrong address. It may also show up as a missing wrap at the stop page, which is visible as soon as a frame crosses the last ring page. A miscounted length or next-page value does not show until the final header cycles of that frame, in the header bytes and on `curPgNext`. A controller left in the wrong state makes the next frame lose bytes or commit twice. The bench therefore checks exact store contents, write totals and commit counts after each frame, including frames that follow aborted or overlapping ones.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BODY,
    ST_PAD,
    ST_HDR,
    ST_DROP
  } rxState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic       loadFrame;
    logic       storeByte;
    logic       storePad;
    logic       storeHdr;
    logic [1:0] hdrSel;
    logic       commit;
  } rxStrobe_t;

  localparam logic [7:0] RX_STATUS_OK = 8'h01;

endpackage

// File: rtl/rxr_ctrl.sv
module rxr_ctrl
  import rxr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      inValid,
  input  logic      inStart,
  input  logic      inLast,
  input  logic      stopCmd,
  input  logic      roomOk,
  input  logic      shortAfter,
  output rxStrobe_t strobe,
  output logic      idle
);

  rxState_t   state, nxtState;
  logic [1:0] hdrIdx;

  always_comb begin
    strobe        = '0;
    strobe.hdrSel = hdrIdx;
    nxtState      = state;
    unique case (state)
      ST_IDLE: begin
        if (inValid && inStart) begin
          if (stopCmd || !roomOk) begin
            nxtState = inLast ? ST_IDLE : ST_DROP;
          end else begin
            strobe.loadFrame = 1'b1;
            strobe.storeByte = 1'b1;
            if (inLast) nxtState = shortAfter ? ST_PAD : ST_HDR;
            else        nxtState = ST_BODY;
          end
        end
      end
      ST_BODY: begin
        if (inValid) begin
          if (inStart) begin
            // early restart: abandon both frames
            nxtState = inLast ? ST_IDLE : ST_DROP;
          end else begin
            strobe.storeByte = 1'b1;
            if (inLast) nxtState = shortAfter ? ST_PAD : ST_HDR;
          end
        end
      end
      ST_PAD: begin
        strobe.storePad = 1'b1;
        if (!shortAfter) nxtState = ST_HDR;
      end
      ST_HDR: begin
        strobe.storeHdr = 1'b1;
        if (hdrIdx == 2'd3) begin
          strobe.commit = 1'b1;
          nxtState      = ST_IDLE;
        end
      end
      ST_DROP: begin
        if (inValid && inLast) nxtState = ST_IDLE;
      end
      default: nxtState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      hdrIdx <= 2'd0;
    end else begin
      state  <= nxtState;
      hdrIdx <= (state == ST_HDR) ? hdrIdx + 2'd1 : 2'd0;
    end
  end

  assign idle = (state == ST_IDLE);

endmodule

// File: rtl/rxr_datapath.sv
module rxr_datapath
  import rxr_pkg::*;
#(
  parameter int PAGE_W    = 8,
  parameter int LEN_W     = 16,
  parameter int MAX_FRAME = 1514,
  parameter int MIN_FRAME = 60
) (
  input  logic                clk,
  input  logic                rst_n,
  input  rxStrobe_t           strobe,
  input  logic [7:0]          inData,
  input  logic [PAGE_W-1:0]   curPg,
  input  logic [PAGE_W-1:0]   ringStart,
  input  logic [PAGE_W-1:0]   ringStop,
  input  logic [PAGE_W-1:0]   boundaryPg,
  output logic                roomOk,
  output logic                shortAfter,
  output logic                memWe,
  output logic [PAGE_W+7:0]   memAddr,
  output logic [7:0]          memData,
  output logic [PAGE_W-1:0]   nextPg
);

  localparam int HDR_BYTES  = 4;
  localparam int CRC_BYTES  = 4;
  localparam int NEED_BYTES = MAX_FRAME + 4;
  localparam int NEED_PG    = (NEED_BYTES + 255) / 256;
  localparam int SW         = PAGE_W + 2;

  // ---- room check (sampled by control at frame start) ----
  logic signed [SW-1:0] ringPg, availPg;
  always_comb begin
    ringPg = $signed(SW'(ringStop)) - $signed(SW'(ringStart));
    if (curPg < boundaryPg)
      availPg = $signed(SW'(boundaryPg)) - $signed(SW'(curPg));
    else
      availPg = ringPg - ($signed(SW'(curPg)) - $signed(SW'(boundaryPg)));
  end
  assign roomOk = (ringStop > ringStart) && (availPg >= $signed(SW'(NEED_PG)));

  // ---- write pointer ----
  logic [PAGE_W-1:0] wrPg, basePg, srcPg, stepPg;
  logic [7:0]        wrOff, srcOff, stepOff;
  logic [LEN_W-1:0]  byteCnt, cntBase;

  assign srcPg   = strobe.loadFrame ? curPg : wrPg;
  assign srcOff  = strobe.loadFrame ? 8'(HDR_BYTES) : wrOff;
  assign cntBase = strobe.loadFrame ? '0 : byteCnt;

  always_comb begin
    stepOff = srcOff + 8'd1;
    stepPg  = srcPg;
    if (srcOff == 8'hFF) begin
      if ({1'b0, srcPg} + 1'b1 == {1'b0, ringStop}) stepPg = ringStart;
      else                                          stepPg = srcPg + 1'b1;
    end
  end

  assign shortAfter = (32'(cntBase) + 1) < MIN_FRAME;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrPg    <= '0;
      wrOff   <= '0;
      basePg  <= '0;
      byteCnt <= '0;
    end else begin
      if (strobe.loadFrame) basePg <= curPg;
      if (strobe.storeByte || strobe.storePad) begin
        wrPg    <= stepPg;
        wrOff   <= stepOff;
        byteCnt <= cntBase + 1'b1;
      end
    end
  end

  // ---- length and next-page link ----
  logic [LEN_W-1:0] total;
  logic [LEN_W:0]   spanPg, sumPg, ringSz, wrapPg;
  always_comb begin
    total  = byteCnt + LEN_W'(HDR_BYTES);
    spanPg = ({1'b0, total} + (LEN_W+1)'(CRC_BYTES + 255)) >> 8;
    sumPg  = (LEN_W+1)'(basePg) + spanPg;
    ringSz = (LEN_W+1)'(ringStop) - (LEN_W+1)'(ringStart);
    wrapPg = (sumPg >= (LEN_W+1)'(ringStop)) ? sumPg - ringSz : sumPg;
  end
  assign nextPg = PAGE_W'(wrapPg);

  // ---- store port ----
  logic [7:0] hdrByte;
  always_comb begin
    unique case (strobe.hdrSel)
      2'd0:    hdrByte = RX_STATUS_OK;
      2'd1:    hdrByte = 8'(nextPg);
      2'd2:    hdrByte = 8'(total);
      default: hdrByte = 8'(total >> 8);
    endcase
  end

  assign memWe   = strobe.storeByte | strobe.storePad | strobe.storeHdr;
  assign memAddr = strobe.storeHdr ? {basePg, 6'b0, strobe.hdrSel} : {srcPg, srcOff};
  assign memData = strobe.storeHdr ? hdrByte : (strobe.storePad ? 8'h00 : inData);

endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
  import rxr_pkg::*;
#(
  parameter int PAGE_W    = 8,
  parameter int LEN_W     = 16,
  parameter int MAX_FRAME = 1514,
  parameter int MIN_FRAME = 60
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stopCmd,
  input  logic [PAGE_W-1:0] ringStart,
  input  logic [PAGE_W-1:0] ringStop,
  input  logic [PAGE_W-1:0] boundaryPg,
  input  logic [PAGE_W-1:0] curPg,
  input  logic              inStart,
  input  logic              inValid,
  input  logic              inLast,
  input  logic [7:0]        inData,
  output logic              memWe,
  output logic [PAGE_W+7:0] memAddr,
  output logic [7:0]        memData,
  output logic              curPgWr,
  output logic [PAGE_W-1:0] curPgNext,
  output logic              rxOkSet
);

  rxStrobe_t strobe;
  logic      roomOk, shortAfter, ctlIdle;

  rxr_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .inValid(inValid), .inStart(inStart), .inLast(inLast),
    .stopCmd(stopCmd), .roomOk(roomOk), .shortAfter(shortAfter),
    .strobe(strobe), .idle(ctlIdle)
  );

  rxr_datapath #(
    .PAGE_W(PAGE_W), .LEN_W(LEN_W), .MAX_FRAME(MAX_FRAME), .MIN_FRAME(MIN_FRAME)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .inData(inData),
    .curPg(curPg), .ringStart(ringStart), .ringStop(ringStop),
    .boundaryPg(boundaryPg), .roomOk(roomOk), .shortAfter(shortAfter),
    .memWe(memWe), .memAddr(memAddr), .memData(memData), .nextPg(curPgNext)
  );

  assign curPgWr = strobe.commit;
  assign rxOkSet = strobe.commit;

endmodule

// File: rtl/rxr_checker.sv
module rxr_checker #(
  parameter int PAGE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ctlIdle,
  input logic              stopCmd,
  input logic [PAGE_W-1:0] ringStart,
  input logic [PAGE_W-1:0] ringStop,
  input logic              inStart,
  input logic              inValid,
  input logic              memWe,
  input logic [PAGE_W+7:0] memAddr,
  input logic              curPgWr,
  input logic [PAGE_W-1:0] curPgNext
);

  assert_stop_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctlIdle && inValid && inStart && stopCmd |-> !memWe);

  assert_bad_ring_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ctlIdle && inValid && inStart && (ringStop <= ringStart) |-> !memWe);

  assert_write_in_ring_R5: assert property (@(posedge clk) disable iff (!rst_n)
    memWe && (ringStop > ringStart) |->
      (memAddr[PAGE_W+7:8] >= ringStart) && (memAddr[PAGE_W+7:8] < ringStop));

  assert_header_last_R10: assert property (@(posedge clk) disable iff (!rst_n)
    curPgWr |-> memWe && (memAddr[7:0] == 8'd3) && $past(memWe) && ($past(memAddr[7:0]) == 8'd2));

  assert_next_in_ring_R8: assert property (@(posedge clk) disable iff (!rst_n)
    curPgWr && (ringStop > ringStart) |-> (curPgNext >= ringStart) && (curPgNext < ringStop));

endmodule

bind rx_ring_writer rxr_checker #(.PAGE_W(PAGE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctlIdle(ctlIdle), .stopCmd(stopCmd),
  .ringStart(ringStart), .ringStop(ringStop), .inStart(inStart), .inValid(inValid),
  .memWe(memWe), .memAddr(memAddr), .curPgWr(curPgWr), .curPgNext(curPgNext)
);

// File: tb/tb_rx_ring_writer.sv
module tb_rx_ring_writer;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0, stopCmd = 0;
  logic [7:0] ringStart = 2, ringStop = 12, boundaryPg = 2, curPg = 2;
  logic inStart = 0, inValid = 0, inLast = 0;
  logic [7:0] inData = 0;
  logic memWe, curPgWr, rxOkSet;
  logic [15:0] memAddr;
  logic [7:0] memData, curPgNext;

  rx_ring_writer dut (.*);

  always #(CLK_P/2) clk = ~clk;

  int checks = 0, errors = 0;
  int writeCnt = 0, commitCnt = 0, rxOkCnt = 0;
  logic [7:0] mem [0:4095];
  logic [15:0] hist [0:3];
  bit hdrOrdOk = 0;

  function automatic logic [7:0] pat(int i, int seed);
    return 8'(i * 7 + seed);
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: samples a quarter period after the falling edge
  initial forever begin
    @(negedge clk);
    #(CLK_P/4);
    if (rst_n) begin
      if (memWe) begin
        mem[memAddr[11:0]] = memData;
        writeCnt++;
        hist[0] = hist[1]; hist[1] = hist[2]; hist[2] = hist[3]; hist[3] = memAddr;
      end
      if (rxOkSet) rxOkCnt++;
      if (curPgWr) begin
        commitCnt++;
        hdrOrdOk = (hist[0] == {curPg, 8'd0}) && (hist[1] == {curPg, 8'd1}) &&
                   (hist[2] == {curPg, 8'd2}) && (hist[3] == {curPg, 8'd3});
        curPg = curPgNext;
      end
    end
  end

  initial begin
    #(CLK_P * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic fillMem(logic [7:0] v);
    for (int a = 0; a < 4096; a++) mem[a] = v;
  endtask

  task automatic setRing(int s, int e, int c, int b);
    @(negedge clk);
    ringStart = 8'(s); ringStop = 8'(e); curPg = 8'(c); boundaryPg = 8'(b);
  endtask

  task automatic sendBytes(int len, int seed, bit withLast);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      inValid = 1; inStart = (i == 0); inLast = withLast && (i == len - 1);
      inData = pat(i, seed);
    end
  endtask

  task automatic sendFrame(int len, int seed);
    sendBytes(len, seed, 1);
    @(negedge clk);
    inValid = 0; inStart = 0; inLast = 0;
  endtask

  task automatic settle();
    repeat (80) @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    #(CLK_P/4);
    check("R13", "memWe after reset", int'(memWe), 0);
    check("R13", "curPgWr after reset", int'(curPgWr), 0);
    check("R13", "writes after reset", writeCnt, 0);
  endtask

  task automatic t_normal();
    int w0, c0, r0;
    setRing(2, 12, 2, 2); fillMem(8'hAA);
    w0 = writeCnt; c0 = commitCnt; r0 = rxOkCnt;
    sendFrame(100, 3); settle();
    check("R4", "first body byte", int'(mem[12'h204]), int'(pat(0, 3)));
    check("R4", "last body byte", int'(mem[12'h204 + 99]), int'(pat(99, 3)));
    check("R4", "byte past body", int'(mem[12'h204 + 100]), 'hAA);
    check("R4", "write total", writeCnt - w0, 104);
    check("R7", "status byte", int'(mem[12'h200]), 1);
    check("R7", "next byte", int'(mem[12'h201]), 3);
    check("R7", "len lo", int'(mem[12'h202]), 104);
    check("R7", "len hi", int'(mem[12'h203]), 0);
    check("R8", "current page", int'(curPg), 3);
    check("R9", "commits", commitCnt - c0, 1);
    check("R9", "rx ok pulses", rxOkCnt - r0, 1);
    check("R10", "header order", int'(hdrOrdOk), 1);
  endtask

  task automatic t_pad();
    int w0;
    setRing(2, 12, 5, 5); fillMem(8'hAA); w0 = writeCnt;
    sendFrame(10, 9); settle();
    check("R6", "last real byte", int'(mem[12'h504 + 9]), int'(pat(9, 9)));
    check("R6", "first pad", int'(mem[12'h504 + 10]), 0);
    check("R6", "last pad", int'(mem[12'h504 + 59]), 0);
    check("R6", "past pad", int'(mem[12'h504 + 60]), 'hAA);
    check("R6", "len lo padded", int'(mem[12'h502]), 64);
    check("R6", "write total", writeCnt - w0, 64);
    setRing(2, 12, 7, 7); w0 = writeCnt;
    sendFrame(60, 4); settle();
    check("R6", "exact 60 no pad writes", writeCnt - w0, 64);
    check("R6", "exact 60 last byte", int'(mem[12'h704 + 59]), int'(pat(59, 4)));
  endtask

  task automatic t_wrap();
    setRing(2, 12, 11, 11); fillMem(8'hAA);
    sendFrame(600, 5); settle();
    check("R5", "end of last page", int'(mem[12'hBFF]), int'(pat(251, 5)));
    check("R5", "wrapped byte", int'(mem[12'h200]), int'(pat(252, 5)));
    check("R5", "final byte", int'(mem[12'h200 + 347]), int'(pat(599, 5)));
    check("R8", "wrapped next", int'(mem[12'hB01]), 4);
    check("R7", "len lo", int'(mem[12'hB02]), 'h5C);
    check("R7", "len hi", int'(mem[12'hB03]), 'h02);
    check("R8", "current page after wrap", int'(curPg), 4);
  endtask

  task automatic t_max();
    setRing(2, 12, 2, 2); fillMem(8'hAA);
    sendFrame(1514, 1); settle();
    check("R7", "max len lo", int'(mem[12'h202]), 'hEE);
    check("R7", "max len hi", int'(mem[12'h203]), 'h05);
    check("R8", "max next page", int'(curPg), 8);
  endtask

  task automatic t_room();
    int w0, c0;
    setRing(2, 12, 4, 8); w0 = writeCnt; c0 = commitCnt;
    sendFrame(20, 2); settle();
    check("R2", "4 free pages writes", writeCnt - w0, 0);
    check("R2", "4 free pages commit", commitCnt - c0, 0);
    check("R2", "page unchanged", int'(curPg), 4);
    setRing(2, 12, 9, 4); c0 = commitCnt;
    sendFrame(20, 2); settle();
    check("R2", "5 free pages wrapped", commitCnt - c0, 0);
    setRing(2, 12, 2, 8); c0 = commitCnt;
    sendFrame(20, 2); settle();
    check("R2", "6 free pages accepted", commitCnt - c0, 1);
    setRing(2, 12, 9, 5); c0 = commitCnt;
    sendFrame(20, 2); settle();
    check("R2", "6 free pages wrapped accepted", commitCnt - c0, 1);
  endtask

  task automatic t_badRing();
    int w0;
    setRing(8, 8, 8, 8); w0 = writeCnt;
    sendFrame(30, 1); settle();
    check("R1", "equal bounds writes", writeCnt - w0, 0);
    setRing(9, 4, 9, 9); w0 = writeCnt;
    sendFrame(30, 1); settle();
    check("R1", "inverted bounds writes", writeCnt - w0, 0);
  endtask

  task automatic t_stop();
    int w0, c0;
    setRing(2, 12, 2, 2); stopCmd = 1; w0 = writeCnt; c0 = commitCnt;
    sendFrame(40, 1); settle();
    check("R3", "stop writes", writeCnt - w0, 0);
    check("R3", "stop commit", commitCnt - c0, 0);
    stopCmd = 0;
  endtask

  task automatic t_abort();
    int c0;
    setRing(2, 12, 3, 3); fillMem(8'hAA); c0 = commitCnt;
    sendBytes(20, 6, 0);
    sendFrame(30, 7); settle();
    check("R11", "abort commit", commitCnt - c0, 0);
    check("R11", "abort page", int'(curPg), 3);
    sendFrame(70, 8); settle();
    check("R11", "recovery commit", commitCnt - c0, 1);
    check("R11", "recovery body", int'(mem[12'h304]), int'(pat(0, 8)));
    check("R11", "recovery next", int'(mem[12'h301]), 4);
  endtask

  task automatic t_busy();
    int w0, c0;
    setRing(2, 12, 2, 2); fillMem(8'hAA); w0 = writeCnt; c0 = commitCnt;
    sendFrame(10, 1);
    sendFrame(5, 2); settle();
    check("R12", "busy commit", commitCnt - c0, 1);
    check("R12", "busy writes", writeCnt - w0, 64);
    check("R12", "busy page", int'(curPg), 3);
    check("R12", "no second frame", int'(mem[12'h304]), 'hAA);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) hist[i] = '0;
    fillMem(8'hAA);
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_normal();
    t_pad();
    t_wrap();
    t_max();
    t_room();
    t_badRing();
    t_stop();
    t_abort();
    t_busy();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule